// File: doc/BRIEF.md
# Card Data Byte FIFO Engine

This block sits between a host register port and the data path of a memory card interface. It holds two independent 32-byte FIFOs: one collects bytes arriving from the card so the host can read them, the other holds bytes the host has written so they can be handed to the card. A data phase is opened by a start pulse that latches the direction and loads a down-counter with the product of the block count and the block length. While the counter is nonzero the engine moves one byte per cycle over a simple valid/ready handshake on the card side, and when it reaches zero the engine goes idle and raises its completion flags.

Host accesses are 1, 2 or 4 bytes wide. A wide read pops several receive bytes and packs them into one word; a wide write unpacks one word into several transmit bytes. A flush input drops whatever the transmit FIFO still holds, which lets software abandon a short final chunk. An abort input ends a data phase at once, leaving the completion flags clear. Serialisation onto the card bus, CRC generation and timeouts live elsewhere.

Top module: `card_byte_fifo_engine`

## Requirements
- R1: Each FIFO holds at most 32 bytes; with 32 bytes in the receive FIFO `card_rx_ready` is low, and a host write stores only as many bytes as there are free transmit slots.
- R2: A start pulse loads the byte count `xfer_blocks * xfer_blk_len`, and exactly that many bytes cross the card handshake before the phase ends (a zero product ends the phase one cycle after start).
- R3: `xfer_dir_tx` = 1 selects transmit and 0 selects receive; in receive mode `card_tx_valid` stays low and in transmit mode `card_rx_ready` stays low.
- R4: In receive mode `card_rx_ready` is high while bytes remain and the receive FIFO holds fewer than 32 bytes; every accepted card byte sets `rx_req`.
- R5: In transmit mode `card_tx_valid` is high while bytes remain and the transmit FIFO is not empty, carrying the oldest byte; `tx_req` is set after each cycle that ends with bytes still remaining.
- R6: `host_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. The first FIFO byte of an access sits in the most significant byte lane of that access (lane N-1 for an N-byte access, lane 0 = bits 7:0). A read with fewer bytes available returns only those, with the remaining lower lanes zero; a write stops when the FIFO is full.
- R7: A host read clears `rx_req` unless a card byte is accepted in the same cycle; a host write clears `tx_req` for that cycle, and it is raised again on the next cycle if bytes remain.
- R8: When the count reaches zero `busy` falls and `data_done` is set; `prog_done` is also set for a transmit phase. Both flags, `rx_req` and `tx_req` are cleared by the next start; all outputs are low after reset.
- R9: A `tx_flush` pulse empties the transmit FIFO; bytes held before it are never offered to the card.
- R10: `xfer_abort` drops `busy` on the next edge without setting `data_done` or `prog_done`, and takes priority over a start in the same cycle.
- R11: A start empties both FIFOs, so leftover receive bytes of an earlier phase cannot be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| xfer_start | input | 1 | Opens a data phase |
| xfer_dir_tx | input | 1 | Direction latched at start: 1 transmit, 0 receive |
| xfer_blocks | input | CNT_W (16) | Number of blocks |
| xfer_blk_len | input | LEN_W (12) | Bytes per block |
| xfer_abort | input | 1 | Ends the active phase without completion |
| tx_flush | input | 1 | Discards transmit FIFO contents |
| host_size | input | 2 | Access width code |
| host_rd | input | 1 | Host read of the receive FIFO this cycle |
| host_rdata | output | 32 | Packed receive bytes for the access |
| host_wr | input | 1 | Host write to the transmit FIFO this cycle |
| host_wdata | input | 32 | Word to unpack into transmit bytes |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| busy | output | 1 | Data phase active |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | Data phase completed |
| prog_done | output | 1 | Transmit phase completed |

## Verification
The bench aims at short reads that find fewer bytes than the access width, where a wrong design would put data in the low lanes or leave stale bytes where zeros belong, and at writes into a nearly full transmit FIFO, where a wrong design would overwrite the oldest byte. It fills the receive FIFO with no host reads to show that the card is throttled at 32 bytes instead of the pointer wrapping onto unread data. A flush before the final chunk and an abort partway through show that dropped bytes never reach the card and that an aborted phase cannot raise the done flags, and a zero-length phase shows that completion is not lost when no byte ever moves.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

  // Host access is at most one 32-bit word.
  localparam int HOST_LANES = 4;
  // Width of a per-cycle byte count (0..HOST_LANES).
  localparam int NB_W = $clog2(HOST_LANES) + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } host_size_e;

  function automatic logic [NB_W-1:0] size_bytes(input logic [1:0] code);
    case (host_size_e'(code))
      SZ_BYTE: size_bytes = NB_W'(1);
      SZ_HALF: size_bytes = NB_W'(2);
      default: size_bytes = NB_W'(HOST_LANES);
    endcase
  endfunction

endpackage

// File: rtl/cdf_byte_fifo.sv
module cdf_byte_fifo #(
  parameter int DEPTH     = 32,
  parameter int IN_LANES  = 1,
  parameter int OUT_LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic [cdf_pkg::NB_W-1:0]     push_n,
  input  logic [IN_LANES*8-1:0]        push_bytes,
  input  logic [cdf_pkg::NB_W-1:0]     pop_n,
  output logic [OUT_LANES*8-1:0]       head_bytes,
  output logic [$clog2(DEPTH):0]       level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] head_q, head_d;
  logic [CW-1:0] level_q, level_d;
  logic [AW-1:0] tail;

  assign tail  = head_q + level_q[AW-1:0];
  assign level = level_q;

  always_comb begin
    head_d  = head_q;
    level_d = level_q;
    if (clr) begin
      level_d = '0;
    end else begin
      head_d  = head_q + AW'(pop_n);
      level_d = level_q + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      level_q <= '0;
    end else begin
      head_q  <= head_d;
      level_q <= level_d;
    end
  end

  // Storage has no reset; only entries below level are ever observed.
  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int i = 0; i < IN_LANES; i++) begin
        if (i < int'(push_n)) begin
          mem[tail + AW'(i)] <= push_bytes[8*i +: 8];
        end
      end
    end
  end

  for (genvar g = 0; g < OUT_LANES; g++) begin : g_peek
    assign head_bytes[8*g +: 8] = mem[head_q + AW'(g)];
  end

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));
  // R1
  push_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (({1'b0, level_q} + (CW+1)'(push_n)) <= (CW+1)'(DEPTH)));
  // R6
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (CW'(pop_n) <= level_q));

endmodule

// File: rtl/cdf_host_lanes.sv
module cdf_host_lanes #(
  parameter int DEPTH = 32
) (
  input  logic [1:0]                                host_size,
  input  logic                                      host_rd,
  input  logic                                      host_wr,
  input  logic [$clog2(DEPTH):0]                    rx_level,
  input  logic [$clog2(DEPTH):0]                    tx_level,
  input  logic [cdf_pkg::HOST_LANES*8-1:0]          rx_head,
  input  logic [cdf_pkg::HOST_LANES*8-1:0]          wdata,
  output logic [cdf_pkg::NB_W-1:0]                  rx_take,
  output logic [cdf_pkg::HOST_LANES*8-1:0]          rdata,
  output logic [cdf_pkg::NB_W-1:0]                  tx_put,
  output logic [cdf_pkg::HOST_LANES*8-1:0]          tx_bytes
);
  localparam int LANES = cdf_pkg::HOST_LANES;
  localparam int NB_W  = cdf_pkg::NB_W;

  int nb, rx_avail, space, tx_fit;

  always_comb begin
    nb       = int'(cdf_pkg::size_bytes(host_size));
    rx_avail = (int'(rx_level) < nb) ? int'(rx_level) : nb;
    space    = DEPTH - int'(tx_level);
    tx_fit   = (space < nb) ? space : nb;
    rdata    = '0;
    tx_bytes = '0;
    for (int i = 0; i < LANES; i++) begin
      // Oldest byte lands in the most significant lane of the access.
      if (i < rx_avail) rdata[8*(nb-1-i) +: 8] = rx_head[8*i +: 8];
      if (i < nb)       tx_bytes[8*i +: 8]     = wdata[8*(nb-1-i) +: 8];
    end
    rx_take = host_rd ? NB_W'(rx_avail) : '0;
    tx_put  = host_wr ? NB_W'(tx_fit)   : '0;
  end

endmodule

// File: rtl/cdf_xfer_ctrl.sv
module cdf_xfer_ctrl #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             rx_beat,
  input  logic             tx_beat,
  input  logic             host_rd,
  input  logic             host_wr,
  output logic             active,
  output logic             dir_tx,
  output logic             left_nz,
  output logic             rx_req,
  output logic             tx_req,
  output logic             data_done,
  output logic             prog_done
);
  localparam int REM_W = CNT_W + LEN_W;

  logic [REM_W-1:0] remain_q, remain_d, remain_nx;
  logic active_q, active_d, dir_q, dir_d;
  logic rxr_q, rxr_d, txr_q, txr_d, dd_q, dd_d, pd_q, pd_d;
  logic beat;

  assign beat      = rx_beat | tx_beat;
  assign remain_nx = remain_q - REM_W'(beat);

  always_comb begin
    active_d = active_q;
    remain_d = remain_nx;
    dir_d    = dir_q;
    dd_d     = dd_q;
    pd_d     = pd_q;
    if (abort) begin
      active_d = 1'b0;
    end else if (start) begin
      active_d = 1'b1;
      remain_d = REM_W'(blk_cnt) * REM_W'(blk_len);
      dir_d    = dir_in;
      dd_d     = 1'b0;
      pd_d     = 1'b0;
    end else if (active_q && (remain_nx == '0)) begin
      active_d = 1'b0;
      dd_d     = 1'b1;
      pd_d     = dir_q;
    end

    if (start && !abort)  rxr_d = 1'b0;
    else if (rx_beat)     rxr_d = 1'b1;
    else if (host_rd)     rxr_d = 1'b0;
    else                  rxr_d = rxr_q;

    if ((start && !abort) || host_wr) txr_d = 1'b0;
    else txr_d = txr_q | (active_q && dir_q && (remain_nx != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
      dir_q    <= 1'b0;
      rxr_q    <= 1'b0;
      txr_q    <= 1'b0;
      dd_q     <= 1'b0;
      pd_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      remain_q <= remain_d;
      dir_q    <= dir_d;
      rxr_q    <= rxr_d;
      txr_q    <= txr_d;
      dd_q     <= dd_d;
      pd_q     <= pd_d;
    end
  end

  assign active    = active_q;
  assign dir_tx    = dir_q;
  assign left_nz   = (remain_q != '0);
  assign rx_req    = rxr_q;
  assign tx_req    = txr_q;
  assign data_done = dd_q;
  assign prog_done = pd_q;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && beat && !start && !abort) |=> (remain_q == $past(remain_q) - REM_W'(1)));
  // R4
  beat_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (active_q && (remain_q != '0)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dd_q) |-> !active_q);
  // R8
  prog_implies_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> dd_q);
  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!active_q && !$rose(dd_q)));

endmodule

// File: rtl/card_byte_fifo_engine.sv
module card_byte_fifo_engine #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_dir_tx,
  input  logic [CNT_W-1:0] xfer_blocks,
  input  logic [LEN_W-1:0] xfer_blk_len,
  input  logic             xfer_abort,
  input  logic             tx_flush,
  input  logic [1:0]       host_size,
  input  logic             host_rd,
  output logic [31:0]      host_rdata,
  input  logic             host_wr,
  input  logic [31:0]      host_wdata,
  input  logic             card_rx_valid,
  input  logic [7:0]       card_rx_data,
  output logic             card_rx_ready,
  output logic             card_tx_valid,
  output logic [7:0]       card_tx_data,
  input  logic             card_tx_ready,
  output logic             busy,
  output logic             rx_req,
  output logic             tx_req,
  output logic             data_done,
  output logic             prog_done
);
  localparam int LW    = $clog2(DEPTH) + 1;
  localparam int NB_W  = cdf_pkg::NB_W;
  localparam int LANES = cdf_pkg::HOST_LANES;

  logic            dir_tx, left_nz, start_eff;
  logic            rx_beat, tx_beat;
  logic [LW-1:0]   rx_level, tx_level;
  logic [LANES*8-1:0] rx_head, tx_bytes;
  logic [7:0]      tx_head;
  logic [NB_W-1:0] rx_take, tx_put;

  assign start_eff     = xfer_start && !xfer_abort;
  assign card_rx_ready = busy && !dir_tx && left_nz && (rx_level < LW'(DEPTH));
  assign card_tx_valid = busy && dir_tx && left_nz && (tx_level != '0);
  assign card_tx_data  = tx_head;
  assign rx_beat       = card_rx_ready && card_rx_valid;
  assign tx_beat       = card_tx_valid && card_tx_ready;

  cdf_xfer_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .abort     (xfer_abort),
    .dir_in    (xfer_dir_tx),
    .blk_cnt   (xfer_blocks),
    .blk_len   (xfer_blk_len),
    .rx_beat   (rx_beat),
    .tx_beat   (tx_beat),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .active    (busy),
    .dir_tx    (dir_tx),
    .left_nz   (left_nz),
    .rx_req    (rx_req),
    .tx_req    (tx_req),
    .data_done (data_done),
    .prog_done (prog_done)
  );

  cdf_host_lanes #(.DEPTH(DEPTH)) u_lanes (
    .host_size (host_size),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .rx_head   (rx_head),
    .wdata     (host_wdata),
    .rx_take   (rx_take),
    .rdata     (host_rdata),
    .tx_put    (tx_put),
    .tx_bytes  (tx_bytes)
  );

  cdf_byte_fifo #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) u_rx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_eff),
    .push_n     (NB_W'(rx_beat)),
    .push_bytes (card_rx_data),
    .pop_n      (rx_take),
    .head_bytes (rx_head),
    .level      (rx_level)
  );

  cdf_byte_fifo #(.DEPTH(DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) u_tx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_eff | tx_flush),
    .push_n     (tx_put),
    .push_bytes (tx_bytes),
    .pop_n      (NB_W'(tx_beat)),
    .head_bytes (tx_head),
    .level      (tx_level)
  );

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !xfer_start) |=> (tx_level == '0));
  // R11
  start_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_eff |=> ((rx_level == '0) && (tx_level == '0)));
  // R3
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rx_ready && card_tx_valid));

endmodule

// File: tb/sim_card_byte_fifo_engine.sv
`timescale 1ns/1ps
module sim_card_byte_fifo_engine;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic xfer_start, xfer_dir_tx, xfer_abort, tx_flush;
  logic [15:0] xfer_blocks;
  logic [11:0] xfer_blk_len;
  logic [1:0]  host_size;
  logic        host_rd, host_wr;
  logic [31:0] host_rdata, host_wdata;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic [7:0]  card_rx_data, card_tx_data;
  logic        busy, rx_req, tx_req, data_done, prog_done;

  always #2.5 clk = ~clk;

  card_byte_fifo_engine u0 (.*);

  int checks = 0, failures = 0;
  byte unsigned rxq[$], txq[$];
  bit m_active, m_dir, m_rxr, m_txr, m_dd, m_pd;
  int m_rem, beats;
  byte unsigned card_next;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input bit [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk_flags();
    chk(busy == m_active, "R8", "busy", busy, m_active);
    chk(data_done == m_dd, "R8", "data_done", data_done, m_dd);
    chk(prog_done == m_pd, "R8", "prog_done", prog_done, m_pd);
    chk(rx_req == m_rxr, "R7", "rx_req", rx_req, m_rxr);
    chk(tx_req == m_txr, "R5", "tx_req", tx_req, m_txr);
  endtask

  task automatic idle_inputs();
    xfer_start = 0; xfer_abort = 0; tx_flush = 0;
    host_rd = 0; host_wr = 0; card_rx_valid = 0; card_tx_ready = 0;
  endtask

  task automatic cycle(input bit rd, input bit wr, input bit [1:0] sz,
                       input bit [31:0] wd, input bit cv, input bit cr);
    int n, k, sp;
    bit rb, tb, exp_rdy, exp_vld;
    logic [31:0] er;
    @(negedge clk);
    idle_inputs();
    host_rd = rd; host_wr = wr; host_size = sz; host_wdata = wd;
    card_rx_valid = cv; card_rx_data = card_next; card_tx_ready = cr;
    #1;
    chk_flags();
    exp_rdy = m_active && !m_dir && m_rem != 0 && rxq.size() < DEPTH;
    exp_vld = m_active && m_dir && m_rem != 0 && txq.size() > 0;
    chk(card_rx_ready == exp_rdy, m_dir ? "R3" : "R4", "card_rx_ready", card_rx_ready, exp_rdy);
    chk(card_tx_valid == exp_vld, m_dir ? "R5" : "R3", "card_tx_valid", card_tx_valid, exp_vld);
    if (exp_vld) chk(card_tx_data == txq[0], "R6", "card_tx_data", card_tx_data, txq[0]);
    n = nbytes(sz);
    k = (rxq.size() < n) ? rxq.size() : n;
    if (rd) begin
      er = 0;
      for (int i = 0; i < k; i++) er[8*(n-1-i) +: 8] = rxq[i];
      chk(host_rdata == er, "R6", "host_rdata", host_rdata, er);
      repeat (k) void'(rxq.pop_front());
    end
    rb = exp_rdy && cv;
    tb = exp_vld && cr;
    sp = DEPTH - txq.size();
    if (tb) void'(txq.pop_front());
    if (wr) for (int i = 0; i < ((sp < n) ? sp : n); i++) txq.push_back(wd[8*(n-1-i) +: 8]);
    if (rb) begin rxq.push_back(card_next); card_next++; end
    if (rb || tb) begin m_rem--; beats++; end
    m_rxr = rb ? 1'b1 : (rd ? 1'b0 : m_rxr);
    m_txr = wr ? 1'b0 : (m_txr | (m_active && m_dir && m_rem != 0));
    if (m_active && m_rem == 0) begin m_active = 0; m_dd = 1; m_pd = m_dir; end
  endtask

  task automatic do_start(input bit dir, input int cnt, input int len);
    @(negedge clk);
    idle_inputs();
    #1; chk_flags();
    xfer_start = 1; xfer_dir_tx = dir;
    xfer_blocks = 16'(cnt); xfer_blk_len = 12'(len);
    @(posedge clk); #1;
    xfer_start = 0;
    m_active = 1; m_dir = dir; m_rem = cnt * len; m_dd = 0; m_pd = 0;
    m_rxr = 0; m_txr = 0; rxq.delete(); txq.delete(); beats = 0;
  endtask

  task automatic run_random(input bit dir, input int cnt, input int len);
    int guard = 0;
    do_start(dir, cnt, len);
    while ((m_active || rxq.size() > 0) && guard < 3000) begin
      cycle(!dir && ($urandom % 3 == 0), dir && ($urandom % 3 != 0),
            2'($urandom % 4), $urandom, ($urandom % 4) != 0, ($urandom % 3) != 0);
      guard++;
    end
    cycle(0, 0, 0, 0, 0, 0);
    chk(beats == cnt * len, "R2", "bytes moved", beats, cnt * len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle_inputs();
    xfer_dir_tx = 0; xfer_blocks = 0; xfer_blk_len = 0;
    host_size = 0; host_wdata = 0; card_rx_data = 0;
    card_next = 8'h10;
    m_active = 0; m_dir = 0; m_rem = 0; m_rxr = 0; m_txr = 0; m_dd = 0; m_pd = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R8 reset state
    chk_flags();
    chk(card_rx_ready == 0 && card_tx_valid == 0, "R8", "reset handshake", {card_rx_ready, card_tx_valid}, 0);

    // R6 short read: two bytes present, word read
    do_start(0, 1, 2);
    cycle(0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 1, 0);
    cycle(1, 0, 2'd2, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);

    // R1 receive FIFO full throttles the card
    do_start(0, 1, 40);
    repeat (DEPTH + 4) cycle(0, 0, 0, 0, 1, 0);
    chk(card_rx_ready == 0, "R1", "ready at full", card_rx_ready, 0);
    chk(rxq.size() == DEPTH, "R1", "model level", rxq.size(), DEPTH);
    repeat (12) cycle(1, 0, 2'd2, 0, 1, 0);

    // R1 transmit overfill: 9 word writes with card stalled
    do_start(1, 1, 36);
    repeat (9) cycle(0, 1, 2'd2, $urandom, 0, 0);
    chk(txq.size() == DEPTH, "R1", "tx model level", txq.size(), DEPTH);
    repeat (60) cycle(0, ($urandom % 2) == 1, 2'd2, $urandom, 0, 1);

    // R9 flush the pending chunk
    do_start(1, 1, 8);
    cycle(0, 1, 2'd2, 32'hDEADBEEF, 0, 0);
    cycle(0, 1, 2'd1, 32'h0000CAFE, 0, 0);
    @(negedge clk); idle_inputs(); tx_flush = 1;
    @(posedge clk); #1;
    tx_flush = 0; txq.delete();
    m_txr = m_txr | (m_active && m_dir && m_rem != 0);
    chk(card_tx_valid == 0, "R9", "valid after flush", card_tx_valid, 0);
    cycle(0, 1, 2'd2, 32'hA1A2A3A4, 0, 0);
    chk(txq[0] == 8'hA1, "R6", "model head", txq[0], 8'hA1);
    repeat (20) cycle(0, 1, 2'd2, 32'hB1B2B3B4, 0, 1);

    // R10 abort mid receive
    do_start(0, 1, 20);
    repeat (5) cycle(0, 0, 0, 0, 1, 0);
    @(negedge clk); idle_inputs(); xfer_abort = 1; xfer_start = 1;
    @(posedge clk); #1;
    xfer_abort = 0; xfer_start = 0;
    m_active = 0;
    chk(busy == 0, "R10", "busy after abort", busy, 0);
    chk(data_done == 0, "R10", "done after abort", data_done, 0);
    chk(card_rx_ready == 0, "R10", "ready after abort", card_rx_ready, 0);
    cycle(0, 0, 0, 0, 1, 0);

    // R11 start empties leftover receive bytes
    do_start(0, 1, 4);
    @(negedge clk); idle_inputs(); host_rd = 1; host_size = 2'd2;
    #1;
    chk(host_rdata == 32'h0, "R11", "rdata after start", host_rdata, 0);
    @(posedge clk); #1; host_rd = 0;
    m_rxr = 0;
    repeat (4) cycle(0, 0, 0, 0, 1, 0);
    repeat (3) cycle(1, 0, 2'd0, 0, 0, 0);

    // R2 zero-length transmit phase
    do_start(1, 3, 0);
    cycle(0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    chk(prog_done == 1, "R8", "prog_done zero length", prog_done, 1);

    // Random phases in both directions
    for (int r = 0; r < 12; r++) begin
      run_random(r[0], 1 + ($urandom % 3), 1 + ($urandom % 40));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule